// File: doc/BRIEF.md
# Broadcast Spike Router Hub

This block is the central hub of a star-connected spiking network. A single upstream producer presents spike packets over a valid/stall handshake. Each packet is 39 bits wide and carries its own time-step value, so downstream cores need no time-step counter of their own. The hub looks at the spike flag of every packet it accepts. Only packets flagged as spike events are kept; all others are consumed and discarded.

Kept packets are queued in order in a FIFO. The oldest entry is presented to every attached neuron-core port at the same time, so one star hop reaches every core. Each port completes its own valid/ready handshake. A port that has taken the current packet is masked until every other port has taken it too. Only then is the entry retired and the next one presented.

An occupancy watcher drives a registered stall back to the producer whenever the FIFO is full. Packets are therefore never dropped for lack of space.

Top module: `spike_bcast_router`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `in_stall` is 0 and every bit of `out_valid` is 0.
- R2: An upstream packet is taken on a rising clock edge where `in_valid` is 1 and `in_stall` is 0. If bit 38 (spike flag) of a taken packet is 0, the packet is discarded and never appears on any port.
- R3: `in_stall` is 1 exactly when the FIFO holds FIFO_DEPTH spike packets. A packet that arrives while the FIFO is full is held off, not lost, and is taken once an entry retires.
- R4: `out_pkt` carries the oldest buffered packet unchanged in all 39 bits, including the time step in bits [37:30] and the index/payload in bits [29:0]. It stays stable until that packet retires.
- R5: Every spike packet is delivered exactly once on each of the NUM_PORTS ports. After port i completes a handshake (`out_valid[i]` and `out_ready[i]` both 1 at an edge), `out_valid[i]` stays 0 until the packet retires.
- R6: A packet retires only on the edge where the last outstanding port completes its handshake. The next buffered packet is presented on the following cycle.
- R7: Spike packets reach each port in the order in which they were taken from upstream, whatever stall pattern the output side applies.
- R8: A spike packet taken into an empty FIFO drives all `out_valid` bits to 1 on the cycle after it is taken. While the FIFO is empty, `out_valid` is all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream packet present |
| in_pkt | input | 39 | Upstream packet: [38] spike flag, [37:30] time step, [29:0] index and payload |
| in_stall | output | 1 | Registered hold-off toward upstream, high when the FIFO is full |
| out_valid | output | NUM_PORTS | Per-port packet offer |
| out_pkt | output | 39 | Packet shared by all ports (oldest FIFO entry) |
| out_ready | input | NUM_PORTS | Per-port acceptance |

## Verification
Corruption of a pointer or of the occupancy count shows up at the port on the next presented packet. It appears either as a value out of injection order or as a packet repeated or skipped, and it is caught at the first output handshake after the fault. A wrong delivered mask shows at once in two ways. A port may see the same packet twice, which the per-port order model reports on that port's next handshake. Or a packet may retire early, so a lagging port misses it and the final per-port counts disagree. A wrong stall is exposed within one cycle of the FIFO reaching or leaving full occupancy: either a packet is lost or a free slot goes unused.

// File: rtl/spk_router_pkg.sv
package spk_router_pkg;
  localparam int PKT_W     = 39;
  localparam int SPIKE_BIT = 38;
  localparam int TS_MSB    = 37;
  localparam int TS_LSB    = 30;

  typedef logic [PKT_W-1:0] spk_pkt_t;

  function automatic logic pkt_is_spike(input spk_pkt_t p);
    return p[SPIKE_BIT];
  endfunction

  function automatic logic [TS_MSB-TS_LSB:0] pkt_tstep(input spk_pkt_t p);
    return p[TS_MSB:TS_LSB];
  endfunction

  function automatic int occ_next(input int cnt, input logic wr, input logic rd);
    return cnt + int'(wr) - int'(rd);
  endfunction

  function automatic int ring_next(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/spk_fifo.sv
module spk_fifo
  import spk_router_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  spk_pkt_t      wdata,
  input  logic          pop,
  output spk_pkt_t      rdata,
  output logic [CW-1:0] count,
  output logic          empty
);
  spk_pkt_t      mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
      cnt_q <= CW'(occ_next(int'(cnt_q), push, pop));
    end
  end

  assign rdata = mem[rd_ptr];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/spk_stall_ctrl.sv
module spk_stall_ctrl
  import spk_router_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          push,
  input  logic          pop,
  output logic          stall
);
  logic stall_q;
  logic full_after;

  // full now, or one short of full with a write landing this edge
  assign full_after = (occ_next(int'(count), push, pop) == DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= full_after;
  end

  assign stall = stall_q;
endmodule

// File: rtl/spk_bcast_tracker.sv
module spk_bcast_tracker #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  input  logic [NPORT-1:0] ready,
  output logic [NPORT-1:0] valid,
  output logic             retire
);
  logic [NPORT-1:0] taken_q;
  logic [NPORT-1:0] fire;
  logic [NPORT-1:0] taken_or_fire;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign valid[g]         = head_valid & ~taken_q[g];
    assign fire[g]          = valid[g] & ready[g];
    assign taken_or_fire[g] = taken_q[g] | fire[g];

    always_ff @(posedge clk) begin
      if (!rst_n)      taken_q[g] <= 1'b0;
      else if (retire) taken_q[g] <= 1'b0;
      else             taken_q[g] <= taken_or_fire[g];
    end
  end

  assign retire = head_valid & (&taken_or_fire);
endmodule

// File: rtl/spike_bcast_router.sv
module spike_bcast_router
  import spk_router_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [38:0]          in_pkt,
  output logic                 in_stall,
  output logic [NUM_PORTS-1:0] out_valid,
  output logic [38:0]          out_pkt,
  input  logic [NUM_PORTS-1:0] out_ready
);
  logic          take;
  logic          push;
  logic          pop;
  logic          empty;
  logic [CW-1:0] fifo_cnt;
  spk_pkt_t      head;

  assign take = in_valid & ~in_stall;
  assign push = take & pkt_is_spike(in_pkt);

  spk_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (in_pkt),
    .pop   (pop),
    .rdata (head),
    .count (fifo_cnt),
    .empty (empty)
  );

  spk_stall_ctrl #(.DEPTH(FIFO_DEPTH)) u_stall (
    .clk   (clk),
    .rst_n (rst_n),
    .count (fifo_cnt),
    .push  (push),
    .pop   (pop),
    .stall (in_stall)
  );

  spk_bcast_tracker #(.NPORT(NUM_PORTS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (~empty),
    .ready      (out_ready),
    .valid      (out_valid),
    .retire     (pop)
  );

  assign out_pkt = head;
endmodule

// File: rtl/spike_bcast_router_chk.sv
module spike_bcast_router_chk #(
  parameter int NUM_PORTS  = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [38:0]          in_pkt,
  input logic                 in_stall,
  input logic [NUM_PORTS-1:0] out_valid,
  input logic [38:0]          out_pkt,
  input logic [NUM_PORTS-1:0] out_ready,
  input logic                 push,
  input logic                 pop,
  input logic [CW-1:0]        fifo_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(fifo_cnt) < FIFO_DEPTH)); // R3

  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    in_stall == (int'(fifo_cnt) == FIFO_DEPTH)); // R3

  AST_DROP_NONSPIKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_stall && !in_pkt[38]) |-> !push); // R2

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|out_valid) && !pop) |=> $stable(out_pkt)); // R4

  AST_RETIRE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fifo_cnt != '0)); // R6

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == '0) |-> (out_valid == '0)); // R8

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_once
    AST_PORT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[g] && out_ready[g] && !pop) |=> !out_valid[g]); // R5
  end
endmodule

bind spike_bcast_router spike_bcast_router_chk #(
  .NUM_PORTS  (NUM_PORTS),
  .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_pkt    (in_pkt),
  .in_stall  (in_stall),
  .out_valid (out_valid),
  .out_pkt   (out_pkt),
  .out_ready (out_ready),
  .push      (push),
  .pop       (pop),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/spike_bcast_router_tb.sv
module spike_bcast_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP         = 4;
  localparam int DEPTH      = 16;
  localparam int NVEC       = 12;
  localparam int WDOG       = 50000;

  // {forward expected, packet}; packet = {spike flag, time step, index/payload}
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'd1,   30'h0000_0011},
    {1'b0, 1'b0, 8'd1,   30'h0000_0012},
    {1'b1, 1'b1, 8'd2,   30'h3FFF_FFFF},
    {1'b1, 1'b1, 8'd2,   30'h0000_0000},
    {1'b0, 1'b0, 8'd3,   30'h1555_5555},
    {1'b1, 1'b1, 8'd255, 30'h2AAA_AAAA},
    {1'b1, 1'b1, 8'd4,   30'h0123_4567},
    {1'b0, 1'b0, 8'd4,   30'h3FFF_FFFF},
    {1'b1, 1'b1, 8'd5,   30'h0000_0400},
    {1'b1, 1'b1, 8'd0,   30'h0000_0001},
    {1'b0, 1'b0, 8'd6,   30'h0000_0002},
    {1'b1, 1'b1, 8'd7,   30'h1000_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [38:0]   in_pkt = '0;
  logic          in_stall;
  logic [NP-1:0] out_valid;
  logic [38:0]   out_pkt;
  logic [NP-1:0] out_ready = '0;

  int          checks = 0;
  int          fails  = 0;
  int          exp_n  = 0;
  logic [38:0] exp_mem [256];
  int          port_cnt [NP];
  logic        rand_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spike_bcast_router #(.NUM_PORTS(NP), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
    .in_stall(in_stall), .out_valid(out_valid), .out_pkt(out_pkt),
    .out_ready(out_ready)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // random output-side stall
  always begin
    @(negedge clk); #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rand_mode) out_ready = lfsr[NP-1:0];
  end

  // per-port delivery monitor: R4, R5, R7
  initial for (int i = 0; i < NP; i++) port_cnt[i] = 0;
  always begin
    @(negedge clk); #4;
    if (rst_n) begin
      for (int i = 0; i < NP; i++) begin
        if (out_valid[i] && out_ready[i]) begin
          if (port_cnt[i] >= exp_n)
            check(1'b0, "R5 extra delivery", 64'(port_cnt[i]), 64'(exp_n));
          else
            check(out_pkt === exp_mem[port_cnt[i]], "R4/R7 packet order",
                  64'(out_pkt), 64'(exp_mem[port_cnt[i]]));
          port_cnt[i]++;
        end
      end
    end
  end

  task automatic inject(input logic [38:0] pkt, input logic fwd);
    @(negedge clk); #2;
    in_valid = 1'b1;
    in_pkt   = pkt;
    #1;
    while (in_stall) begin
      @(negedge clk); #3;
    end
    if (fwd) begin
      exp_mem[exp_n] = pkt;
      exp_n++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    logic all_in;
    all_in = 1'b0;
    while (!all_in && guard < 2000) begin
      @(negedge clk); #4;
      all_in = 1'b1;
      for (int i = 0; i < NP; i++) if (port_cnt[i] != exp_n) all_in = 1'b0;
      guard++;
    end
    for (int i = 0; i < NP; i++)
      check(port_cnt[i] == exp_n, "R5 per-port count", 64'(port_cnt[i]), 64'(exp_n));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(in_stall == 1'b0 && out_valid == '0, "R1 in reset", 64'({in_stall, out_valid}), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #4;
    check(in_stall == 1'b0 && out_valid == '0, "R1 after reset", 64'({in_stall, out_valid}), 64'(0));

    // R8 latency into empty FIFO, R5/R6 partial acceptance
    inject({1'b1, 8'd9, 30'h0000_0ABC}, 1'b1);
    @(negedge clk); #4;
    check(out_valid == '1, "R8 valid one cycle after take", 64'(out_valid), 64'({NP{1'b1}}));
    @(negedge clk); #2; out_ready = 4'b0001;
    @(negedge clk); #2; out_ready = '0; #2;
    check(out_valid == 4'b1110, "R5 port masked after accept", 64'(out_valid), 64'(4'b1110));
    check(out_pkt == {1'b1, 8'd9, 30'h0000_0ABC}, "R6 held until all accept", 64'(out_pkt), 64'({1'b1, 8'd9, 30'h0000_0ABC}));
    @(negedge clk); #2; out_ready = 4'b1110;
    @(negedge clk); #2; out_ready = '0; #2;
    check(out_valid == '0, "R6 retired after last port", 64'(out_valid), 64'(0));
    drain();

    // R2 non-spike discarded
    inject({1'b0, 8'd9, 30'h0000_0FFF}, 1'b0);
    repeat (2) @(negedge clk); #4;
    check(out_valid == '0, "R2 non-spike dropped", 64'(out_valid), 64'(0));

    // R3 fill to full and hold off
    for (int k = 0; k < DEPTH; k++) begin
      inject({1'b1, 8'(k), 30'(k * 7 + 3)}, 1'b1);
      if (k == DEPTH - 2) begin
        @(negedge clk); #4;
        check(in_stall == 1'b0, "R3 stall low at depth-1", 64'(in_stall), 64'(0));
      end
    end
    @(negedge clk); #4;
    check(in_stall == 1'b1, "R3 stall high when full", 64'(in_stall), 64'(1));
    @(negedge clk); #2; in_valid = 1'b1; in_pkt = {1'b1, 8'd77, 30'h0000_7777};
    repeat (3) @(negedge clk); #4;
    check(in_stall == 1'b1, "R3 stall held while full", 64'(in_stall), 64'(1));
    @(negedge clk); #2; in_valid = 1'b0; out_ready = '1;
    @(negedge clk); #2; out_ready = '0; #2;
    check(in_stall == 1'b0, "R3 stall drops after retire", 64'(in_stall), 64'(0));
    inject({1'b1, 8'd77, 30'h0000_7777}, 1'b1);
    rand_mode = 1'b1;
    drain();

    // table walk under random output stalls: R2, R4, R7
    for (int pass = 0; pass < 3; pass++)
      for (int v = 0; v < NVEC; v++)
        inject(VEC[v][38:0] ^ {1'b0, 8'(pass), 30'(pass)}, VEC[v][39]);
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule